// File: doc/BRIEF.md
# DMA Control Register Unit

This block is the control-register side of a four-channel DMA controller. It decodes the eight control offsets of the controller's register window. It holds the global command byte, one mode byte per channel, a per-channel mask and an 8-bit status byte. The upper half of the status byte records pending requests and the lower half records terminal counts. Address and count registers, and the transfer engine itself, live in neighbouring blocks. The only link to the channel register block is a pulse that resets its byte-pointer flip-flop.

Devices raise or drop a channel's request through a level input. The block turns each change of that level into a set or clear of the channel's request bit. Software can post or withdraw a request with a register write, and the same write clears that channel's terminal-count bit. The transfer engine reports a terminal count with a one-cycle pulse. Reading the status clears every terminal-count bit, so each completion is seen once. Power-on reset has the same effect as a master-clear write.

Top module: `dma_ctrl_regs`

## Requirements
- R1: A write to offset 0 loads `command_o` only when the data is 0x00 or 0x04; any other value leaves the command unchanged.
- R2: A write to offset 1 selects channel data[1:0], sets its request bit (status bit channel+4) when data[2] is 1 or clears it when data[2] is 0, and in both cases clears its terminal-count bit (status bit channel).
- R3: A write to offset 2 sets mask bit data[1:0] when data[2] is 1 and clears it when data[2] is 0; the other mask bits are unchanged.
- R4: A write to offset 3 stores the whole data byte as the mode of channel data[1:0], shown on `mode_o[8*ch +: 8]` (operation in bits [3:2], auto-init in bit 4, decrement in bit 5, transfer mode in bits [7:6]); other channels' modes are unchanged.
- R5: A write to offset 5 (master clear), and reset, set the mask to all ones and the command and status to 0. Master clear leaves the mode bytes as they are and overrides any request or terminal-count event in the same cycle.
- R6: A write to offset 6 clears every mask bit; a write to offset 7 loads the mask from data[3:0].
- R7: `ff_clear_o` is 1 during a write to offset 4 or offset 5 and 0 in every other cycle.
- R8: While `rd_en_i` is 1 with offset 0, `rdata_o` shows the status byte; at that clock edge the terminal-count nibble clears, except that a `tc_i` pulse in the same cycle still sets its bit.
- R9: A read of offset 7 returns {4'b0, mask}; reads of offsets 1 to 6, and `rdata_o` while `rd_en_i` is 0, return 0.
- R10: A 0-to-1 change of `dreq_i[ch]` sets the channel's request bit and a 1-to-0 change clears it. Such a change wins over a software request write to the same channel in the same cycle.
- R11: A one-cycle pulse on `tc_i[ch]` sets the channel's terminal-count bit, which stays set until a status read, a software request to that channel or master clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| ofs_i | input | 3 | Control offset within the window (0 to 7) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| dreq_i | input | NUM_CH | Device request levels |
| tc_i | input | NUM_CH | Terminal-count pulses from the transfer engine |
| command_o | output | 8 | Command register |
| mask_o | output | NUM_CH | Channel mask, 1 = masked |
| mode_o | output | 8*NUM_CH | Mode bytes, channel 0 in the low byte |
| ff_clear_o | output | 1 | Byte-pointer flip-flop clear pulse |

## Verification
The assertions check on every cycle the properties that depend on one edge. The command only ever holds a legal value, and an illegal write leaves it unchanged. A single-mask write lands on the addressed bit, and a mode write lands on the addressed channel. Master clear and mask clear take effect on the next edge. A request edge or a terminal-count pulse sets its status bit, a status read empties the terminal-count nibble, and the flip-flop pulse appears only during a write. Only the bench's scenarios can show the rest. These are that the whole 256-value command space is filtered, that status reads return the byte before it clears, and that software and device requests interact correctly over several cycles. They also cover reads of the unused offsets.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;

  typedef enum logic [2:0] {
    OFS_CMD_STAT = 3'd0,
    OFS_SWREQ    = 3'd1,
    OFS_MASK_ONE = 3'd2,
    OFS_MODE     = 3'd3,
    OFS_FF_CLR   = 3'd4,
    OFS_MCLR     = 3'd5,
    OFS_MASK_CLR = 3'd6,
    OFS_MASK_ALL = 3'd7
  } ctrl_ofs_e;

  typedef struct packed {
    logic cmd_we;
    logic swreq_we;
    logic mask_one_we;
    logic mode_we;
    logic ff_clr;
    logic mclr;
    logic mask_clr_we;
    logic mask_all_we;
    logic rd_status;
    logic rd_mask;
  } ctrl_strobe_t;

  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CH_SEL_W = 2;
  // Only this command bit is supported; any other set bit rejects the write
  localparam logic [DATA_W-1:0] CMD_LEGAL_BITS = 8'h04;

endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode
  import dma_ctrl_pkg::*;
(
  input  logic         wr_en_i,
  input  logic         rd_en_i,
  input  logic [2:0]   ofs_i,
  output ctrl_strobe_t strobe_o
);

  always_comb begin
    strobe_o = '0;
    if (wr_en_i) begin
      unique case (ctrl_ofs_e'(ofs_i))
        OFS_CMD_STAT: strobe_o.cmd_we      = 1'b1;
        OFS_SWREQ:    strobe_o.swreq_we    = 1'b1;
        OFS_MASK_ONE: strobe_o.mask_one_we = 1'b1;
        OFS_MODE:     strobe_o.mode_we     = 1'b1;
        OFS_FF_CLR:   strobe_o.ff_clr      = 1'b1;
        OFS_MCLR:     strobe_o.mclr        = 1'b1;
        OFS_MASK_CLR: strobe_o.mask_clr_we = 1'b1;
        OFS_MASK_ALL: strobe_o.mask_all_we = 1'b1;
        default: ;
      endcase
    end
    if (rd_en_i) begin
      strobe_o.rd_status = (ctrl_ofs_e'(ofs_i) == OFS_CMD_STAT);
      strobe_o.rd_mask   = (ctrl_ofs_e'(ofs_i) == OFS_MASK_ALL);
    end
  end

endmodule

// File: rtl/dma_ctrl_status.sv
module dma_ctrl_status
  import dma_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_status_i,
  input  logic                swreq_we_i,
  input  logic                mclr_i,
  input  logic [CH_SEL_W-1:0] sel_ch_i,
  input  logic                req_set_i,
  input  logic [NUM_CH-1:0]   tc_i,
  input  logic [NUM_CH-1:0]   dreq_i,
  output logic [NUM_CH-1:0]   tc_o,
  output logic [NUM_CH-1:0]   req_o
);

  logic [NUM_CH-1:0] tc_q, tc_d, req_q, req_d, dreq_q;
  logic [NUM_CH-1:0] rise, fall;

  assign rise = dreq_i & ~dreq_q;
  assign fall = ~dreq_i & dreq_q;

  always_comb begin
    tc_d  = tc_q;
    req_d = req_q;
    if (rd_status_i) tc_d = '0;
    if (swreq_we_i) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (sel_ch_i == CH_SEL_W'(i)) begin
          req_d[i] = req_set_i;
          tc_d[i]  = 1'b0;
        end
      end
    end
    tc_d  = tc_d | tc_i;
    // device edges win over software requests
    req_d = (req_d | rise) & ~fall;
    if (mclr_i) begin
      tc_d  = '0;
      req_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q   <= '0;
      req_q  <= '0;
      dreq_q <= '0;
    end else begin
      tc_q   <= tc_d;
      req_q  <= req_d;
      dreq_q <= dreq_i;
    end
  end

  assign tc_o  = tc_q;
  assign req_o = req_q;

  AST_RD_CLEARS_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status_i && !swreq_we_i && (tc_i == '0) |=> (tc_q == '0)); // R8

  AST_MCLR_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_i |=> (tc_q == '0) && (req_q == '0)); // R5

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_DREQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dreq_i[g] && !dreq_q[g] && !mclr_i |=> req_q[g]); // R10
    AST_DREQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dreq_i[g] && dreq_q[g] |=> !req_q[g]); // R10
    AST_TC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_i[g] && !mclr_i |=> tc_q[g]); // R11
  end

endmodule

// File: rtl/dma_ctrl_cfg.sv
module dma_ctrl_cfg
  import dma_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_we_i,
  input  logic                     mask_one_we_i,
  input  logic                     mode_we_i,
  input  logic                     mclr_i,
  input  logic                     mask_clr_we_i,
  input  logic                     mask_all_we_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        command_o,
  output logic [NUM_CH-1:0]        mask_o,
  output logic [DATA_W*NUM_CH-1:0] mode_o
);

  logic [DATA_W-1:0]   cmd_q;
  logic [NUM_CH-1:0]   mask_q;
  logic [CH_SEL_W-1:0] sel_ch;
  logic                cmd_ok;

  assign sel_ch = wdata_i[CH_SEL_W-1:0];
  assign cmd_ok = (wdata_i & ~CMD_LEGAL_BITS) == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cmd_q <= '0;
    else if (mclr_i)             cmd_q <= '0;
    else if (cmd_we_i && cmd_ok) cmd_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            mask_q <= '1;
    else if (mclr_i)        mask_q <= '1;
    else if (mask_clr_we_i) mask_q <= '0;
    else if (mask_all_we_i) mask_q <= wdata_i[NUM_CH-1:0];
    else if (mask_one_we_i) begin
      for (int i = 0; i < NUM_CH; i++)
        if (sel_ch == CH_SEL_W'(i)) mask_q[i] <= wdata_i[2];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_mode
    logic [DATA_W-1:0] mode_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       mode_q <= '0;
      else if (mode_we_i && sel_ch == CH_SEL_W'(g)) mode_q <= wdata_i;
    end
    assign mode_o[g*DATA_W +: DATA_W] = mode_q;

    AST_MODE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_we_i && sel_ch == CH_SEL_W'(g) |=> mode_q == $past(wdata_i)); // R4
    AST_MASK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask_one_we_i && !mclr_i && !mask_clr_we_i && !mask_all_we_i && sel_ch == CH_SEL_W'(g)
      |=> mask_q[g] == $past(wdata_i[2])); // R3
  end

  assign command_o = cmd_q;
  assign mask_o    = mask_q;

  AST_CMD_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == '0) || (cmd_q == CMD_LEGAL_BITS)); // R1
  AST_CMD_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && !mclr_i && (wdata_i & ~CMD_LEGAL_BITS) != '0 |=> $stable(cmd_q)); // R1
  AST_MCLR_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_i |=> (mask_q == '1) && (cmd_q == '0)); // R5
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_clr_we_i && !mclr_i |=> (mask_q == '0)); // R6

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [2:0]               ofs_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic [NUM_CH-1:0]        dreq_i,
  input  logic [NUM_CH-1:0]        tc_i,
  output logic [DATA_W-1:0]        command_o,
  output logic [NUM_CH-1:0]        mask_o,
  output logic [DATA_W*NUM_CH-1:0] mode_o,
  output logic                     ff_clear_o
);

  localparam int unsigned STAT_W = 2 * NUM_CH;

  ctrl_strobe_t      strobe;
  logic [NUM_CH-1:0] tc, req;
  logic [STAT_W-1:0] status;

  dma_ctrl_decode u_decode (
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .ofs_i    (ofs_i),
    .strobe_o (strobe)
  );

  dma_ctrl_status #(.NUM_CH(NUM_CH)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_status_i (strobe.rd_status),
    .swreq_we_i  (strobe.swreq_we),
    .mclr_i      (strobe.mclr),
    .sel_ch_i    (wdata_i[CH_SEL_W-1:0]),
    .req_set_i   (wdata_i[2]),
    .tc_i        (tc_i),
    .dreq_i      (dreq_i),
    .tc_o        (tc),
    .req_o       (req)
  );

  dma_ctrl_cfg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_we_i      (strobe.cmd_we),
    .mask_one_we_i (strobe.mask_one_we),
    .mode_we_i     (strobe.mode_we),
    .mclr_i        (strobe.mclr),
    .mask_clr_we_i (strobe.mask_clr_we),
    .mask_all_we_i (strobe.mask_all_we),
    .wdata_i       (wdata_i),
    .command_o     (command_o),
    .mask_o        (mask_o),
    .mode_o        (mode_o)
  );

  assign status     = {req, tc};
  assign ff_clear_o = strobe.ff_clr | strobe.mclr;

  always_comb begin
    rdata_o = '0;
    if (strobe.rd_status)    rdata_o = DATA_W'(status);
    else if (strobe.rd_mask) rdata_o = DATA_W'(mask_o);
  end

  AST_FF_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ff_clear_o |-> wr_en_i); // R7
  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0)); // R9

endmodule

// File: tb/dma_ctrl_regs_test.sv
`timescale 1ns/1ps
module dma_ctrl_regs_test;

  localparam int NUM_CH = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  ofs = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  dreq = '0, tc = '0;
  logic [7:0]  command;
  logic [3:0]  mask;
  logic [31:0] mode;
  logic        ff_clear;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] exp_cmd;
  logic [3:0] exp_mask, exp_req, exp_tc;
  logic [31:0] exp_mode;
  logic        last_ff;

  always #4 clk = ~clk;

  dma_ctrl_regs #(.NUM_CH(NUM_CH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .ofs_i(ofs), .wdata_i(wdata), .rdata_o(rdata), .dreq_i(dreq),
    .tc_i(tc), .command_o(command), .mask_o(mask), .mode_o(mode),
    .ff_clear_o(ff_clear)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] o, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; ofs = o; wdata = d;
    #1 last_ff = ff_clear;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] o, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; ofs = o;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_status(input string req);
    logic [7:0] v;
    rd(3'd0, v);
    check(req, {24'd0, v}, {24'd0, exp_req, exp_tc});
    exp_tc = '0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    exp_cmd = 0; exp_mask = 4'hF; exp_req = 0; exp_tc = 0; exp_mode = 0;

    // R5 reset state
    check("R5 reset cmd", {24'd0, command}, 32'd0);
    check("R5 reset mask", {28'd0, mask}, 32'hF);
    check("R4 reset mode", mode, 32'd0);
    check_status("R5 reset status");

    // R1 full command sweep
    for (int i = 0; i < 256; i++) begin
      wr(3'd0, 8'(i));
      if (i == 0 || i == 4) exp_cmd = 8'(i);
      check("R1 command filter", {24'd0, command}, {24'd0, exp_cmd});
      if (i == 3) wr(3'd0, 8'h04);
      if (i == 3) exp_cmd = 8'h04;
    end

    // R4 mode writes
    for (int ch = 0; ch < 4; ch++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] d;
        d = {6'(8'h15 * (p + 1) + ch), 2'(ch)};
        wr(3'd3, d);
        exp_mode[ch*8 +: 8] = d;
        check("R4 mode lane", mode, exp_mode);
      end
    end

    // R3 single mask, R9 mask read
    for (int d = 0; d < 8; d++) begin
      wr(3'd2, 8'(d));
      exp_mask[d[1:0]] = d[2];
      check("R3 single mask", {28'd0, mask}, {28'd0, exp_mask});
      rd(3'd7, v);
      check("R9 mask read", {24'd0, v}, {28'd0, exp_mask});
    end
    wr(3'd2, 8'h06); exp_mask[2] = 1'b1;
    wr(3'd2, 8'h04); exp_mask[0] = 1'b1;
    check("R3 set bits", {28'd0, mask}, {28'd0, exp_mask});

    // R6 clear all / load all
    wr(3'd6, 8'hFF); exp_mask = 0;
    check("R6 clear all", {28'd0, mask}, 32'd0);
    wr(3'd7, 8'hA5); exp_mask = 4'h5;
    check("R6 load all", {28'd0, mask}, 32'h5);
    rd(3'd7, v);
    check("R9 mask read upper zero", {24'd0, v}, 32'h05);

    // R2 software requests, with terminal counts preloaded (R11)
    for (int d = 0; d < 8; d++) begin
      @(negedge clk); tc = 4'hF;
      @(negedge clk); tc = 4'h0;
      exp_tc = 4'hF;
      wr(3'd1, 8'(d));
      exp_req[d[1:0]] = d[2];
      exp_tc[d[1:0]] = 1'b0;
      check_status("R2 software request");
    end
    wr(3'd1, 8'h00); exp_req[0] = 0;
    wr(3'd1, 8'h01); exp_req[1] = 0;
    wr(3'd1, 8'h02); exp_req[2] = 0;
    wr(3'd1, 8'h03); exp_req[3] = 0;
    check_status("R2 all cleared");

    // R11 / R8: pulse, read shows then clears
    @(negedge clk); tc = 4'b1010;
    @(negedge clk); tc = 4'h0;
    exp_tc = 4'b1010;
    check_status("R11 tc pulse read");
    check_status("R8 tc cleared by read");
    // R8 read in same cycle as tc pulse
    @(negedge clk); tc = 4'b0100; rd_en = 1'b1; ofs = 3'd0;
    #1 v = rdata;
    check("R8 read before pulse lands", {24'd0, v}, 32'd0);
    @(negedge clk); tc = 4'h0; rd_en = 1'b0;
    exp_tc = 4'b0100;
    check_status("R8 pulse kept across read");

    // R10 device request edges
    @(negedge clk); dreq = 4'b0010;
    @(negedge clk); exp_req = 4'b0010;
    check_status("R10 rise sets");
    wr(3'd1, 8'h01); exp_req = 4'b0000;
    check_status("R10 software clear with level held");
    @(negedge clk); dreq = 4'b0000;
    wr(3'd1, 8'h05); exp_req = 4'b0010;
    check_status("R2 software set");
    @(negedge clk); dreq = 4'b1000;
    @(negedge clk); exp_req = 4'b1010;
    check_status("R10 second channel rise");
    @(negedge clk); dreq = 4'b0000;
    @(negedge clk); exp_req = 4'b0010;
    check_status("R10 fall clears");
    // same-cycle software clear and device rise on channel 1
    @(negedge clk); dreq = 4'b0010; wr_en = 1'b1; ofs = 3'd1; wdata = 8'h01;
    @(negedge clk); wr_en = 1'b0;
    exp_req = 4'b0010;
    check_status("R10 rise beats software clear");

    // R7 flip-flop clear pulse
    for (int o = 0; o < 8; o++) begin
      if (o == 5) continue;
      wr(3'(o), (o == 0) ? 8'h00 : (o == 3) ? 8'h00 : (o == 7) ? 8'h05 : (o == 2) ? 8'h00 : (o == 1) ? 8'h05 : 8'h00);
      check("R7 ff clear pulse", {31'd0, last_ff}, (o == 4) ? 32'd1 : 32'd0);
    end
    exp_cmd = 0; exp_mask = 4'h5; exp_mode[7:0] = 8'h00; exp_req = 4'b0010;
    check("R7 side effects mask", {28'd0, mask}, {28'd0, exp_mask});

    // R9 unused offsets read zero
    for (int o = 1; o < 7; o++) begin
      rd(3'(o), v);
      check("R9 unused read", {24'd0, v}, 32'd0);
    end

    // R5 master clear
    wr(3'd0, 8'h04);
    @(negedge clk); tc = 4'b0001;
    @(negedge clk); tc = 4'b0000;
    wr(3'd5, 8'h00);
    check("R5 mclr ff pulse", {31'd0, last_ff}, 32'd1);
    check("R5 mclr cmd", {24'd0, command}, 32'd0);
    check("R5 mclr mask", {28'd0, mask}, 32'hF);
    check("R5 mclr keeps mode", mode, exp_mode);
    exp_req = 0; exp_tc = 0;
    check_status("R5 mclr status");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule